// File: doc/BRIEF.md
# DC Offset Canceller

This block strips a slowly varying DC component from a stream of signed converter samples that arrive at up to one per clock. A first-order leaky integrator tracks the running mean of the accepted samples. Its rounded, range-limited value is subtracted from each sample before the sample leaves the block. The loop is built from adders and shifters only. Its time constant is a power of two in clocks, chosen by a 4-bit code.

A tracking cycle may be switched off, which clears the estimate, or frozen, which keeps the current estimate and still subtracts it. The current estimate is also driven on a port so that it can be observed. Corrected samples come out one clock after they go in, with their own valid strobe.

Top module: `dc_offset_canceller`

## Requirements
- R1: While reset is asserted and just after it, `out_valid` is 0, `out_sample` is 0 and `offset_est` is 0.
- R2: When `corr_en` is 0 for an accepted sample, the sample leaves the block one clock later unchanged, even on the cycle where `corr_en` has just fallen.
- R3: `out_valid` equals `in_valid` delayed by exactly one clock. `out_sample` only changes when a sample is accepted.
- R4: With `corr_en`=1, `hold_est`=0 and `in_valid`=1, the internal accumulator A (the estimate scaled by 2^30) becomes A + ((x·2^30 − A) >>> (18+code)) at each clock, with an arithmetic shift. `offset_est` is round-half-up(A/2^30), clamped. The accepted sample leaves as x minus the estimate held before that update.
- R5: Each step of the code value doubles the time constant. After the same run of samples, code 1 gives an estimate about half that of code 0.
- R6: Codes 12 to 15 behave exactly like code 11, which is the longest time constant of 2^29 clocks.
- R7: While `hold_est`=1 the estimate does not change, and it is still subtracted from every accepted sample.
- R8: `offset_est` never leaves the range [−82, +82], and it settles at the bound when the mean lies outside it.
- R9: The corrected sample saturates to the signed 14-bit range [−8192, 8191] and never wraps.
- R10: While `in_valid`=0 the estimate does not change.
- R11: A clock with `corr_en`=0 clears the estimate to 0. When `corr_en` returns to 1, tracking restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 14 | Signed input sample |
| corr_en | input | 1 | Enables tracking and subtraction; 0 clears the estimate |
| tc_code | input | 4 | Time-constant code; time constant is 2^(18+code) clocks, and codes 12 to 15 act as 11 |
| hold_est | input | 1 | Freezes the estimate while it is still subtracted |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 14 | Corrected, saturated signed sample |
| offset_est | output | 14 | Current rounded, clamped offset estimate (signed) |

## Verification
A sample presented before clock edge k is due on `out_sample` and `out_valid` just after edge k. The estimate that includes that sample is due on `offset_est` after the same edge, while the output sample uses the estimate from before that edge. The bench drives inputs on the falling edge. It steps its own accumulator model once per rising edge, computing the expected output from the old estimate before updating the model, and it compares a quarter period after that edge. Freeze, idle and clear are checked on the very next edge, and the saturation corners are checked against literal values as well as the model.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;

  // Operating mode seen by the estimator in a given cycle
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_TRACK  = 2'd1,
    MODE_FREEZE = 2'd2,
    MODE_IDLE   = 2'd3
  } dcoc_mode_e;

  // Map a time-constant code onto the code actually used; codes above
  // the last legal one fall back to the longest time constant.
  function automatic logic [3:0] legal_code(input logic [3:0] code,
                                            input logic [3:0] max_code);
    return (code > max_code) ? max_code : code;
  endfunction

  // Mode selection from the control inputs
  function automatic dcoc_mode_e pick_mode(input logic en,
                                           input logic hold,
                                           input logic valid);
    if (!en)        return MODE_BYPASS;
    else if (hold)  return MODE_FREEZE;
    else if (!valid) return MODE_IDLE;
    else            return MODE_TRACK;
  endfunction

endpackage

// File: rtl/dcoc_tc_decode.sv
module dcoc_tc_decode #(
  parameter int BASE_SHIFT = 18,
  parameter int MAX_CODE   = 11,
  parameter int SW         = 6
) (
  input  logic [3:0]    tc_code,
  output logic [SW-1:0] shift_amt,
  output logic          reserved_hit
);
  import dcoc_pkg::*;

  localparam logic [3:0] MAX_C = 4'(MAX_CODE);

  logic [3:0] used_code;

  always_comb begin
    used_code    = legal_code(tc_code, MAX_C);
    reserved_hit = (tc_code > MAX_C);
    shift_amt    = SW'(BASE_SHIFT) + SW'(used_code);
  end

endmodule

// File: rtl/dcoc_estimator.sv
module dcoc_estimator #(
  parameter int DW   = 14,
  parameter int FRAC = 30,
  parameter int AW   = DW + FRAC + 2,
  parameter int SW   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic signed [DW-1:0] sample,
  input  logic [SW-1:0]        shift_amt,
  output logic signed [AW-1:0] acc
);

  localparam int EXT = AW - DW - FRAC;

  logic signed [AW-1:0] sample_scaled;
  logic signed [AW-1:0] err;
  logic signed [AW-1:0] delta;

  always_comb begin
    sample_scaled = {{EXT{sample[DW-1]}}, sample, {FRAC{1'b0}}};
    err           = sample_scaled - acc;
    delta         = err >>> shift_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (step) begin
      acc <= acc + delta;
    end
  end

endmodule

// File: rtl/dcoc_round_clamp.sv
module dcoc_round_clamp #(
  parameter int DW    = 14,
  parameter int FRAC  = 30,
  parameter int AW    = DW + FRAC + 2,
  parameter int LIMIT = 82
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [DW-1:0] est,
  output logic                 clamp_hi,
  output logic                 clamp_lo
);

  localparam logic signed [AW-1:0] HALF  = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] LIM_P = AW'(LIMIT);
  localparam logic signed [AW-1:0] LIM_N = -AW'(LIMIT);

  logic signed [AW-1:0] biased;
  logic signed [AW-1:0] whole;

  always_comb begin
    biased   = acc + HALF;
    whole    = biased >>> FRAC;
    clamp_hi = (whole > LIM_P);
    clamp_lo = (whole < LIM_N);
    if (clamp_hi)      est = LIM_P[DW-1:0];
    else if (clamp_lo) est = LIM_N[DW-1:0];
    else               est = whole[DW-1:0];
  end

endmodule

// File: rtl/dcoc_apply.sv
module dcoc_apply #(
  parameter int DW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 bypass,
  input  logic signed [DW-1:0] sample,
  input  logic signed [DW-1:0] est,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic                 sat_hit
);

  localparam logic signed [DW:0] MAXV = DW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [DW:0] MINV = -(DW+1)'(1) <<< (DW - 1);

  logic signed [DW:0]   wide_diff;
  logic signed [DW-1:0] corrected;

  function automatic logic signed [DW-1:0] sat_narrow(input logic signed [DW:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  always_comb begin
    wide_diff = {sample[DW-1], sample} - {est[DW-1], est};
    corrected = sat_narrow(wide_diff);
    sat_hit   = (wide_diff > MAXV) || (wide_diff < MINV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sample <= bypass ? sample : corrected;
      end
    end
  end

endmodule

// File: rtl/dc_offset_canceller.sv
module dc_offset_canceller #(
  parameter int DW         = 14,
  parameter int FRAC       = 30,
  parameter int BASE_SHIFT = 18,
  parameter int MAX_CODE   = 11,
  parameter int LIMIT      = 82
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic                 corr_en,
  input  logic [3:0]           tc_code,
  input  logic                 hold_est,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic signed [DW-1:0] offset_est
);
  import dcoc_pkg::*;

  localparam int AW = DW + FRAC + 2;
  localparam int SW = 6;

  // Named internal events, visible to the checker
  dcoc_mode_e           mode;
  logic                 upd_fire;
  logic                 est_clear;
  logic                 reserved_code;
  logic                 clamp_hi;
  logic                 clamp_lo;
  logic                 sat_hit;
  logic [SW-1:0]        shift_amt;
  logic signed [AW-1:0] acc;

  always_comb begin
    mode      = pick_mode(corr_en, hold_est, in_valid);
    upd_fire  = (mode == MODE_TRACK);
    est_clear = (mode == MODE_BYPASS);
  end

  dcoc_tc_decode #(
    .BASE_SHIFT(BASE_SHIFT),
    .MAX_CODE  (MAX_CODE),
    .SW        (SW)
  ) u_decode (
    .tc_code     (tc_code),
    .shift_amt   (shift_amt),
    .reserved_hit(reserved_code)
  );

  dcoc_estimator #(
    .DW  (DW),
    .FRAC(FRAC),
    .AW  (AW),
    .SW  (SW)
  ) u_est (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (est_clear),
    .step     (upd_fire),
    .sample   (in_sample),
    .shift_amt(shift_amt),
    .acc      (acc)
  );

  dcoc_round_clamp #(
    .DW   (DW),
    .FRAC (FRAC),
    .AW   (AW),
    .LIMIT(LIMIT)
  ) u_round (
    .acc     (acc),
    .est     (offset_est),
    .clamp_hi(clamp_hi),
    .clamp_lo(clamp_lo)
  );

  dcoc_apply #(
    .DW(DW)
  ) u_apply (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bypass    (!corr_en),
    .sample    (in_sample),
    .est       (offset_est),
    .out_valid (out_valid),
    .out_sample(out_sample),
    .sat_hit   (sat_hit)
  );

endmodule

// File: rtl/dcoc_checker.sv
module dcoc_checker #(
  parameter int DW    = 14,
  parameter int LIMIT = 82
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_sample,
  input logic                 corr_en,
  input logic                 hold_est,
  input logic                 upd_fire,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample,
  input logic signed [DW-1:0] offset_est
);

  // Becomes 1 one edge after reset release, so $past never reaches into reset
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_valid_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (out_valid == $past(in_valid)));

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!corr_en && in_valid)) |-> (out_sample == $past(in_sample)));

  p_est_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(offset_est) <= LIMIT) && ($signed(offset_est) >= -LIMIT));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && corr_en && hold_est) |=> $stable(offset_est));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && corr_en && !in_valid) |=> $stable(offset_est));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_en |=> (offset_est == '0));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && out_valid) |->
      ((int'(out_sample) - int'($past(in_sample)) <= LIMIT) &&
       (int'(out_sample) - int'($past(in_sample)) >= -LIMIT)));

  p_step_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> (corr_en && in_valid && !hold_est));

endmodule

bind dc_offset_canceller dcoc_checker #(
  .DW   (DW),
  .LIMIT(LIMIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .corr_en   (corr_en),
  .hold_est  (hold_est),
  .upd_fire  (upd_fire),
  .out_valid (out_valid),
  .out_sample(out_sample),
  .offset_est(offset_est)
);

// File: tb/dc_offset_canceller_bench.sv
module dc_offset_canceller_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [13:0] in_sample = '0;
  logic               corr_en = 1'b0;
  logic [3:0]         tc_code = '0;
  logic               hold_est = 1'b0;
  logic               out_valid;
  logic signed [13:0] out_sample;
  logic signed [13:0] offset_est;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_offset_canceller u_dc_offset_canceller (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .corr_en   (corr_en),
    .tc_code   (tc_code),
    .hold_est  (hold_est),
    .out_valid (out_valid),
    .out_sample(out_sample),
    .offset_est(offset_est)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Control values applied by the next step
  bit       m_en = 0;
  bit       m_hold = 0;
  int       m_code = 0;

  // Reference model state
  longint   ref_acc = 0;
  longint   ref_est = 0;
  longint   ref_y = 0;
  bit       ref_v = 0;
  int       run_bad = 0;

  function automatic longint ref_clamp(input longint a);
    longint r;
    r = (a + (longint'(1) <<< 29)) >>> 30;
    if (r > 82)  r = 82;
    if (r < -82) r = -82;
    return r;
  endfunction

  function automatic longint ref_sat(input longint v);
    if (v > 8191)  return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive on falling edge, step model at rising edge, compare after it
  task automatic step(input int x, input bit v);
    int sh;
    @(negedge clk);
    in_sample = 14'(x);
    in_valid  = v;
    corr_en   = m_en;
    hold_est  = m_hold;
    tc_code   = 4'(m_code);
    @(posedge clk);
    sh = 18 + ((m_code > 11) ? 11 : m_code);
    ref_v = v;
    if (v) ref_y = m_en ? ref_sat(longint'(x) - ref_est) : longint'(x);
    if (!m_en) ref_acc = 0;
    else if (v && !m_hold) ref_acc = ref_acc + (((longint'(x) <<< 30) - ref_acc) >>> sh);
    ref_est = ref_clamp(ref_acc);
    #(CLK_PERIOD/4);
    if (out_valid !== ref_v) run_bad++;
    if (ref_v && (longint'(out_sample) != ref_y)) run_bad++;
    if (longint'(offset_est) != ref_est) run_bad++;
  endtask

  task automatic run(input int x, input bit v, input int n);
    for (int i = 0; i < n; i++) step(x, v);
  endtask

  task automatic model_ok(input string req);
    check(run_bad == 0, req, run_bad, 0);
    run_bad = 0;
  endtask

  task automatic clear_est();
    m_en = 0; m_hold = 0;
    step(0, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(out_valid == 0 && out_sample == 0 && offset_est == 0, "R1 in reset",
          {out_valid, out_sample}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    check(out_valid == 0 && offset_est == 0, "R1 after release", offset_est, 0);
  endtask

  task automatic t_bypass();
    m_en = 0; m_hold = 0; m_code = 0;
    step(8191, 1);  check(out_sample == 8191, "R2 bypass max", out_sample, 8191);
    step(-8192, 1); check(out_sample == -8192, "R2 bypass min", out_sample, -8192);
    check(out_valid == 1, "R3 valid one cycle later", out_valid, 1);
    step(77, 0);    check(out_valid == 0 && out_sample == -8192, "R3 idle holds output", out_sample, -8192);
    model_ok("R2 bypass model");
  endtask

  task automatic t_converge_pos();
    m_en = 1; m_hold = 0; m_code = 0;
    run(8000, 1, 4000);
    model_ok("R4 tracking model code 0");
    check(offset_est == 82, "R8 positive clamp", offset_est, 82);
  endtask

  task automatic t_freeze_and_sat();
    m_hold = 1;
    for (int i = 0; i < 100; i++) begin
      step(5000, 1);
      step(-5000, 1);
    end
    model_ok("R7 frozen model");
    check(offset_est == 82, "R7 estimate frozen", offset_est, 82);
    step(1000, 1);
    check(out_sample == 918, "R7 frozen estimate subtracted", out_sample, 918);
    step(-8192, 1); check(out_sample == -8192, "R9 negative saturation", out_sample, -8192);
    step(-8110, 1); check(out_sample == -8192, "R9 saturation edge", out_sample, -8192);
    step(-8109, 1); check(out_sample == -8191, "R9 just inside range", out_sample, -8191);
    model_ok("R9 model");
  endtask

  task automatic t_disable_restart();
    m_en = 0; m_hold = 0;
    step(100, 1);
    check(out_sample == 100, "R2 bypass on falling enable", out_sample, 100);
    check(offset_est == 0, "R11 estimate cleared", offset_est, 0);
    m_en = 1; m_code = 0;
    run(8000, 1, 100);
    check(offset_est >= 2 && offset_est <= 4, "R11 restart from zero", offset_est, 3);
    model_ok("R11 restart model");
  endtask

  task automatic t_converge_neg();
    clear_est();
    m_en = 1; m_code = 0;
    run(-8192, 1, 4000);
    check(offset_est == -82, "R8 negative clamp", offset_est, -82);
    m_hold = 1;
    step(8191, 1);
    check(out_sample == 8191, "R9 positive saturation", out_sample, 8191);
    model_ok("R9 negative model");
  endtask

  task automatic t_code_ratio();
    longint e0, e1;
    clear_est();
    m_en = 1; m_code = 0;
    run(8000, 1, 1000);
    e0 = offset_est;
    clear_est();
    m_en = 1; m_code = 1;
    run(8000, 1, 1000);
    e1 = offset_est;
    check(e1 > 0 && e1 * 2 >= e0 - 1 && e1 * 2 <= e0 + 1, "R5 code 1 half of code 0", e1 * 2, e0);
    model_ok("R5 model");
  endtask

  task automatic t_reserved(input int code);
    clear_est();
    m_en = 1; m_code = code;
    run(8191, 1, 40000);
    check(offset_est == 1, $sformatf("R6 reserved code %0d acts as 11", code), offset_est, 1);
    model_ok("R6 model");
  endtask

  task automatic t_valid_low();
    clear_est();
    m_en = 1; m_code = 0;
    run(8000, 0, 300);
    check(offset_est == 0, "R10 estimate idle without valid", offset_est, 0);
    check(out_valid == 0, "R3 no output without valid", out_valid, 0);
    step(8000, 1);
    check(out_valid == 1 && out_sample == 8000, "R3 first valid output", out_sample, 8000);
    model_ok("R10 model");
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_converge_pos();
    t_freeze_and_sat();
    t_disable_restart();
    t_converge_neg();
    t_code_ratio();
    t_valid_low();
    t_reserved(12);
    t_reserved(15);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule